// File: doc/BRIEF.md
# Delay-and-Sum Receive Beamformer

This block combines eight parallel echo sample streams into one beam sample per clock. Each receive channel has its own start delay, counted in sample ticks from a line-start strobe. Until that delay runs out, the channel contributes nothing to the beam. Once its delay has run out, each sample is scaled by an unsigned apodization weight. The eight weighted values are then reduced through a registered three-level adder tree. An output-valid flag travels with the sum.

The delay and weight tables are written by a host. A write lands in a shadow copy. The table the datapath uses is refreshed from that shadow only at a line start, or when a focus-update strobe arrives during a line. This lets dynamic focusing swap the delay and weight set while a line is being sampled, while an ordinary host write never disturbs a line already running.

Top module: `echo_beamformer`

## Requirements
- R1: While reset is held, and directly after it, `beam_out` is 0 and `beam_valid` is 0. All delays and weights reset to 0.
- R2: The tick count is 0 in the cycle after a `line_start` edge and rises by one per clock after that. It saturates at 255. In a given cycle, channel c contributes 0 while the tick is below its active delay. From then on it stays enabled for the rest of the line, including after saturation.
- R3: An enabled channel contributes the product of its 10-bit unsigned sample and its 8-bit unsigned active weight. Sample c sits at `smp_in[10*c +: 10]`.
- R4: `beam_out` equals the sum of the eight contributions of one input cycle. It appears four clock edges after those samples are presented: one weighting register, then three adder levels.
- R5: The full-scale sum 8 x 1023 x 255 = 2086920 appears exactly on the 21-bit output.
- R6: `beam_valid` equals the line-active status of the input cycle four edges earlier. It stays low until the first `line_start`.
- R7: A host write goes to the shadow table. `host_wr_sel` 0 selects the delay table and 1 selects the weight table. `host_wr_ch` picks the channel and `host_wr_data` carries the value. The active tables, and so the output, do not change until the next `line_start` or `focus_load`.
- R8: `focus_load` copies both shadow tables into the active tables without restarting the tick count. The new values apply from the next cycle. A copy, whether by `focus_load` or `line_start`, takes the shadow as it stood before any write in the same cycle.
- R9: A `line_start` during a running line resets the tick to 0. Channels with a nonzero delay go back to contributing 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Begins a receive line; restarts the tick and loads the tables |
| focus_load | input | 1 | Loads the shadow tables into the active tables during a line |
| smp_in | input | 80 | Eight packed 10-bit unsigned samples, channel 0 in the low bits |
| host_wr_en | input | 1 | Host table write strobe |
| host_wr_sel | input | 1 | 0 = delay table, 1 = weight table |
| host_wr_ch | input | 3 | Channel index of the write |
| host_wr_data | input | 8 | Delay (ticks) or weight value |
| beam_out | output | 21 | Weighted beam sum |
| beam_valid | output | 1 | Beam sample belongs to an active line |

## Verification
The bench staggers the channel delays so that channels switch on one tick at a time. A design whose compare is off by one shows a wrong sum in exactly the cycle where a channel should first appear. Host writes during a line are checked against the next output samples, so a design that applies writes immediately changes the sum mid-line. A focus update is checked to keep the tick running, while a repeated line start is checked to pull delayed channels back to zero. A delay of 255 checks that a channel turns on at saturation and then stays on. A full-scale case exposes a truncated adder tree, and varying sample patterns catch any latency other than four edges.

// File: rtl/beam_pkg.sv
package beam_pkg;
    typedef enum logic {
        SEL_DELAY  = 1'b0,
        SEL_WEIGHT = 1'b1
    } tbl_sel_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/beam_ctrl.sv
module beam_ctrl
    import beam_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int WW  = 8,
    parameter int CW  = $clog2(NCH),
    parameter int XW  = max_of(DW, WW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_start,
    input  logic                     focus_load,
    input  logic                     wr_en,
    input  logic                     wr_sel,
    input  logic [CW-1:0]            wr_ch,
    input  logic [XW-1:0]            wr_data,
    output logic                     line_act,
    output logic [DW-1:0]            tick,
    output logic [NCH-1:0][DW-1:0]   dly_act,
    output logic [NCH-1:0][WW-1:0]   w_act
);
    typedef struct packed {
        logic                   act;
        logic [DW-1:0]          tick;
        logic [NCH-1:0][DW-1:0] dly_sh;
        logic [NCH-1:0][DW-1:0] dly_act;
        logic [NCH-1:0][WW-1:0] w_sh;
        logic [NCH-1:0][WW-1:0] w_act;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (tbl_sel_e'(wr_sel) == SEL_DELAY) d.dly_sh[wr_ch] = wr_data[DW-1:0];
            else                                 d.w_sh[wr_ch]   = wr_data[WW-1:0];
        end
        if (line_start) begin
            d.act  = 1'b1;
            d.tick = '0;
        end else if (q.act && (q.tick != '1)) begin
            d.tick = q.tick + 1'b1;
        end
        if (line_start || focus_load) begin
            d.dly_act = q.dly_sh;
            d.w_act   = q.w_sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_act = q.act;
    assign tick     = q.tick;
    assign dly_act  = q.dly_act;
    assign w_act    = q.w_act;

    // R7: active tables hold unless a load strobe arrives
    p_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_start || focus_load) |=> ($stable(dly_act) && $stable(w_act)));

    // R8: a load strobe copies the shadow seen in that cycle
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start || focus_load) |=> (dly_act == $past(q.dly_sh)) && (w_act == $past(q.w_sh)));

    // R9: line start restarts the tick
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (tick == '0) && line_act);
endmodule

// File: rtl/beam_weight.sv
module beam_weight #(
    parameter int NCH = 8,
    parameter int SW  = 10,
    parameter int WW  = 8,
    parameter int DW  = 8,
    parameter int PW  = SW + WW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_i,
    input  logic [DW-1:0]          tick_i,
    input  logic [NCH-1:0][SW-1:0] smp_i,
    input  logic [NCH-1:0][DW-1:0] dly_i,
    input  logic [NCH-1:0][WW-1:0] w_i,
    output logic [NCH-1:0][PW-1:0] prod_o
);
    typedef struct packed {
        logic [NCH-1:0][PW-1:0] prod;
    } wt_t;

    wt_t q, d;

    always_comb begin
        d = '0;
        for (int c = 0; c < NCH; c++) begin
            if (act_i && (tick_i >= dly_i[c])) d.prod[c] = PW'(smp_i[c]) * PW'(w_i[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prod_o = q.prod;

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R2: channel silent until its delay expires
        p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!act_i || (tick_i < dly_i[c])) |=> (prod_o[c] == '0));
        // R3: enabled channel carries sample times weight
        p_mult_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act_i && (tick_i >= dly_i[c])) |=>
            (prod_o[c] == PW'($past(smp_i[c])) * PW'($past(w_i[c]))));
    end
endmodule

// File: rtl/beam_tree.sv
module beam_tree #(
    parameter int NCH = 8,
    parameter int IW  = 18,
    parameter int LV  = $clog2(NCH),
    parameter int OW  = IW + LV
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0][IW-1:0] in_i,
    output logic [OW-1:0]          sum_o
);
    localparam int HALF = NCH / 2;
    localparam int AW   = $clog2(LV + 1);

    typedef struct packed {
        logic [LV-1:0][HALF-1:0][OW-1:0] node;
        logic [AW-1:0]                   age;
    } tree_t;

    tree_t q, d;

    always_comb begin
        d = '0;
        for (int n = 0; n < HALF; n++) begin
            d.node[0][n] = OW'(in_i[2*n]) + OW'(in_i[2*n+1]);
        end
        for (int l = 1; l < LV; l++) begin
            for (int n = 0; n < (NCH >> (l + 1)); n++) begin
                d.node[l][n] = q.node[l-1][2*n] + q.node[l-1][2*n+1];
            end
        end
        d.age = (q.age == AW'(LV)) ? q.age : q.age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sum_o = q.node[LV-1][0];

    logic [OW-1:0] in_total;
    always_comb begin
        in_total = '0;
        for (int i = 0; i < NCH; i++) in_total = in_total + OW'(in_i[i]);
    end

    // R4: tree output is the total of its inputs LV edges earlier
    p_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.age == AW'(LV)) |-> (sum_o == $past(in_total, LV)));
endmodule

// File: rtl/echo_beamformer.sv
module echo_beamformer #(
    parameter int NCH = 8,
    parameter int SW  = 10,
    parameter int WW  = 8,
    parameter int DW  = 8,
    parameter int CW  = $clog2(NCH),
    parameter int XW  = beam_pkg::max_of(DW, WW),
    parameter int OW  = SW + WW + $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               focus_load,
    input  logic [NCH*SW-1:0]  smp_in,
    input  logic               host_wr_en,
    input  logic               host_wr_sel,
    input  logic [CW-1:0]      host_wr_ch,
    input  logic [XW-1:0]      host_wr_data,
    output logic [OW-1:0]      beam_out,
    output logic               beam_valid
);
    localparam int PW   = SW + WW;
    localparam int LV   = $clog2(NCH);
    localparam int PIPE = LV + 1;
    localparam int AW   = $clog2(PIPE + 1);

    logic                   line_act;
    logic [DW-1:0]          tick;
    logic [NCH-1:0][DW-1:0] dly_act;
    logic [NCH-1:0][WW-1:0] w_act;
    logic [NCH-1:0][SW-1:0] smp;
    logic [NCH-1:0][PW-1:0] prod;

    assign smp = smp_in;

    beam_ctrl #(.NCH(NCH), .DW(DW), .WW(WW), .CW(CW), .XW(XW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .focus_load(focus_load),
        .wr_en(host_wr_en), .wr_sel(host_wr_sel), .wr_ch(host_wr_ch), .wr_data(host_wr_data),
        .line_act(line_act), .tick(tick), .dly_act(dly_act), .w_act(w_act)
    );

    beam_weight #(.NCH(NCH), .SW(SW), .WW(WW), .DW(DW), .PW(PW)) u_weight (
        .clk(clk), .rst_n(rst_n), .act_i(line_act), .tick_i(tick),
        .smp_i(smp), .dly_i(dly_act), .w_i(w_act), .prod_o(prod)
    );

    beam_tree #(.NCH(NCH), .IW(PW), .LV(LV), .OW(OW)) u_tree (
        .clk(clk), .rst_n(rst_n), .in_i(prod), .sum_o(beam_out)
    );

    typedef struct packed {
        logic [PIPE-1:0] vld;
        logic [AW-1:0]   age;
    } top_t;

    top_t q, d;

    always_comb begin
        d     = q;
        d.vld = {q.vld[PIPE-2:0], line_act};
        d.age = (q.age == AW'(PIPE)) ? q.age : q.age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign beam_valid = q.vld[PIPE-1];

    // R6: valid follows line activity with the datapath latency
    p_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.age == AW'(PIPE)) |-> (beam_valid == $past(line_act, PIPE)));

    // R1: outputs quiet while reset is held
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (beam_out == '0) && !beam_valid);
endmodule

// File: tb/echo_beamformer_test.sv
module echo_beamformer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int SW  = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        focus_load = 1'b0;
    logic [79:0] smp_in = '0;
    logic        host_wr_en = 1'b0;
    logic        host_wr_sel = 1'b0;
    logic [2:0]  host_wr_ch = '0;
    logic [7:0]  host_wr_data = '0;
    logic [20:0] beam_out;
    logic        beam_valid;

    echo_beamformer uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .focus_load(focus_load),
        .smp_in(smp_in), .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_ch(host_wr_ch), .host_wr_data(host_wr_data),
        .beam_out(beam_out), .beam_valid(beam_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    int m_dly_sh[NCH], m_dly[NCH], m_w_sh[NCH], m_w[NCH];
    bit m_act = 0;
    int m_tick = 0;
    longint pipe_s[4];
    bit pipe_v[4];
    int smp_v[NCH];
    bit wr_pend = 0;
    bit wr_sel_p = 0;
    int wr_ch_p = 0;
    int wr_dat_p = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit ls, input bit fl, input string tag);
        longint e = 0;
        chk({tag, " sum"}, beam_out, pipe_s[3]);
        chk("R6 valid", beam_valid, pipe_v[3]);
        if (m_act)
            for (int c = 0; c < NCH; c++)
                if (m_tick >= m_dly[c]) e += longint'(smp_v[c]) * m_w[c];
        for (int i = 3; i > 0; i--) begin
            pipe_s[i] = pipe_s[i-1];
            pipe_v[i] = pipe_v[i-1];
        end
        pipe_s[0] = e;
        pipe_v[0] = m_act;
        line_start = ls;
        focus_load = fl;
        for (int c = 0; c < NCH; c++) smp_in[c*SW +: SW] = 10'(smp_v[c]);
        host_wr_en   = wr_pend;
        host_wr_sel  = wr_sel_p;
        host_wr_ch   = 3'(wr_ch_p);
        host_wr_data = 8'(wr_dat_p);
        if (ls || fl)
            for (int c = 0; c < NCH; c++) begin
                m_dly[c] = m_dly_sh[c];
                m_w[c]   = m_w_sh[c];
            end
        if (ls) begin
            m_act = 1;
            m_tick = 0;
        end else if (m_act && m_tick < 255) begin
            m_tick++;
        end
        if (wr_pend) begin
            if (wr_sel_p) m_w_sh[wr_ch_p] = wr_dat_p;
            else          m_dly_sh[wr_ch_p] = wr_dat_p;
        end
        wr_pend = 0;
        @(negedge clk);
    endtask

    task automatic hw(input bit sel, input int ch, input int val, input string tag);
        wr_pend = 1;
        wr_sel_p = sel;
        wr_ch_p = ch;
        wr_dat_p = val;
        step(0, 0, tag);
    endtask

    task automatic run(input int n, input int seed, input string tag);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < NCH; c++) smp_v[c] = (k * 53 + c * 97 + seed) % 1024;
            step(0, 0, tag);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset sum", beam_out, 0);
        chk("R1 reset valid", beam_valid, 0);
        run(6, 1, "R1 idle");
    endtask

    task automatic t_weights;
        for (int c = 0; c < NCH; c++) hw(1, c, c * 17 + 3, "R3 setup");
        step(1, 0, "R4 start");
        run(12, 7, "R3 R4 weighted");
    endtask

    task automatic t_delay;
        int dl[NCH] = '{0, 3, 5, 1, 7, 2, 6, 4};
        for (int c = 0; c < NCH; c++) hw(0, c, dl[c], "R2 setup");
        for (int c = 0; c < NCH; c++) smp_v[c] = 500 + c;
        step(1, 0, "R2 start");
        for (int k = 0; k < 12; k++) step(0, 0, "R2 stagger");
        run(8, 3, "R2 varied");
    endtask

    task automatic t_sat;
        hw(0, 5, 255, "R2 sat setup");
        for (int c = 0; c < NCH; c++) smp_v[c] = 100 + c;
        step(1, 0, "R2 sat start");
        for (int k = 0; k < 262; k++) step(0, 0, "R2 saturate");
        hw(0, 5, 6, "R2 sat restore");
    endtask

    task automatic t_restart;
        step(1, 0, "R9 start");
        run(10, 11, "R9 first");
        step(1, 0, "R9 restart");
        run(10, 13, "R9 second");
    endtask

    task automatic t_defer;
        hw(1, 0, 0, "R7 write w0");
        hw(0, 1, 200, "R7 write d1");
        run(8, 21, "R7 deferred");
        step(1, 0, "R7 start");
        run(8, 23, "R7 applied");
    endtask

    task automatic t_focus;
        hw(0, 1, 2, "R8 write d1");
        hw(1, 2, 250, "R8 write w2");
        run(4, 31, "R8 before");
        wr_pend = 1; wr_sel_p = 1; wr_ch_p = 3; wr_dat_p = 9;
        step(0, 1, "R8 load");
        run(8, 33, "R8 after");
        step(0, 1, "R8 reload");
        run(6, 35, "R8 second");
    endtask

    task automatic t_max;
        for (int c = 0; c < NCH; c++) hw(1, c, 255, "R5 setup");
        for (int c = 0; c < NCH; c++) hw(0, c, 0, "R5 setup");
        for (int c = 0; c < NCH; c++) smp_v[c] = 1023;
        step(1, 0, "R5 start");
        for (int k = 0; k < 6; k++) step(0, 0, "R5 full scale");
        chk("R5 explicit", beam_out, 2086920);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_dly_sh[c] = 0; m_dly[c] = 0; m_w_sh[c] = 0; m_w[c] = 0; smp_v[c] = 0;
        end
        for (int i = 0; i < 4; i++) begin
            pipe_s[i] = 0; pipe_v[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_weights();
        t_delay();
        t_sat();
        t_restart();
        t_defer();
        t_focus();
        t_max();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule